// File: doc/BRIEF.md
# Shared-Pool Four-Queue FIFO Controller

This block keeps four independent first-in first-out queues in one memory array. The write side and the read side share a single clock. Each side picks its queue with its own address and a select strobe, so the two sides may work on the same queue or on different ones. During reset the controller captures a size for each queue. Each size is a count of fixed-size blocks, and the queues are packed into the pool in order from queue 0 upward. The controller also captures two threshold offsets and a device identity.

A selection is a one-cycle pulse. The write side keeps the old target for the selecting edge and for the edge after it. The read side works in first-word-fall-through fashion: its registered output is reloaded automatically from the chosen queue, and a flag shows whether the output word is valid. The read address can also name a null queue, which reads nothing. A partial reset empties the one queue that is active on both sides and leaves every other queue as it was.

Top module: `mq_fifo`

## Requirements
- R1: During reset, each queue's block count (4 bits per queue, queue 0 in the lowest field) and the device identity are captured. A queue's depth is its block count times BLK_WORDS. A queue with zero blocks is always full and always empty.
- R2: A write selection (`wsel` high) addresses queue `waddr[1:0]` only when `waddr[4:2]` equals the captured identity. On a mismatch no queue is selected, `wr_room` is low and writes are dropped.
- R3: Enabled writes on the selecting edge and on the next edge still go to the previously selected queue. From the second edge after selection they go to the new queue.
- R4: From the cycle after a write selection, `wr_room` is high exactly when the newly selected queue has a free slot. A write to a full queue is dropped and leaves that queue unchanged.
- R5: On the edge after a read selection, a read enable still reads the previous queue. On the second edge the head word of the new queue loads into `rdata`, whether or not `ren` is high.
- R6: When `rd_void` is high and the active read queue holds data, its head word loads on the next edge without `ren`. A `ren` against a valid output and an empty queue sets `rd_void` high. `rdata` changes only when a new valid word loads.
- R7: If the newly selected read queue is empty on the second edge after selection, `rdata` keeps its last word and `rd_void` goes high.
- R8: A read selection with `raddr[2]` high selects the null queue, and one whose `raddr[5:3]` does not match the identity selects nothing. In both cases no queue is read, and `rd_void` is high from the second edge on.
- R9: `prst` empties the one queue that is active on both sides, meaning it was selected on both sides at least two edges earlier. Other queues, the output register and the configuration are untouched. When the two sides have different queues active, `prst` is ignored.
- R10: For the most recently selected queue, `wr_afull_n` is low when its free slots are no more than the almost-full offset. `rd_aempty_n` is low when the words it holds in memory (not counting the output register) are no more than the almost-empty offset. Both are high when no queue is selected.
- R11: After reset, `wr_room` is 0, `rd_void` is 1, `wr_afull_n` and `rd_aempty_n` are 1, and `rdata` is 0.
- R12: Each queue delivers its accepted words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| dev_id | input | 3 | Device identity matched against the address high bits |
| cfg_blocks | input | 16 | Block count per queue, 4 bits each, queue 0 lowest |
| cfg_ae_off | input | 8 | Almost-empty offset |
| cfg_af_off | input | 8 | Almost-full offset |
| wsel | input | 1 | Write queue select strobe |
| waddr | input | 5 | Write address: identity in [4:2], queue in [1:0] |
| wen | input | 1 | Write enable |
| wdata | input | 18 | Write data |
| rsel | input | 1 | Read queue select strobe |
| raddr | input | 6 | Read address: identity in [5:3], null in [2], queue in [1:0] |
| ren | input | 1 | Read enable |
| prst | input | 1 | Partial reset of the queue active on both sides |
| wr_room | output | 1 | High when the selected write queue is not full |
| wr_afull_n | output | 1 | Active-low almost-full |
| rd_aempty_n | output | 1 | Active-low almost-empty |
| rd_void | output | 1 | High when `rdata` is not a valid word |
| rdata | output | 18 | Registered read data |

## Verification
The assertions assume that the identity, block counts and offsets are held constant after reset. They also assume that the block counts add up to no more than the pool, since overlapping queues would break the occupancy bound. The stimulus holds all configuration inputs at one value from before reset onward and allocates six of the eight blocks. The bench uses the identity 5 for every selection except the deliberate mismatch cases. The partial-reset pulses are issued only after both sides have had two full edges to settle on their queues.

// File: rtl/mq_fifo.sv
`timescale 1ns/1ps
module mq_fifo #(
  parameter int DW        = 18,
  parameter int BLK_WORDS = 16,
  parameter int NBLK      = 8,
  parameter int IDW       = 3,
  localparam int DEPTH    = BLK_WORDS * NBLK,
  localparam int AW       = $clog2(DEPTH),
  localparam int BCW      = $clog2(NBLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   dev_id,
  input  logic [4*BCW-1:0] cfg_blocks,
  input  logic [AW:0]      cfg_ae_off,
  input  logic [AW:0]      cfg_af_off,
  input  logic             wsel,
  input  logic [IDW+1:0]   waddr,
  input  logic             wen,
  input  logic [DW-1:0]    wdata,
  input  logic             rsel,
  input  logic [IDW+2:0]   raddr,
  input  logic             ren,
  input  logic             prst,
  output logic             wr_room,
  output logic             wr_afull_n,
  output logic             rd_aempty_n,
  output logic             rd_void,
  output logic [DW-1:0]    rdata
);

  logic [BCW-1:0] blk_q [4];
  logic [AW:0]    ae_q, af_q;
  logic [IDW-1:0] id_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int q = 0; q < 4; q++) blk_q[q] <= cfg_blocks[q*BCW +: BCW];
      ae_q <= cfg_ae_off;
      af_q <= cfg_af_off;
      id_q <= dev_id;
    end

  logic [AW:0]   depth [4];
  logic [AW-1:0] base  [4];
  logic [AW:0]   acc;

  always_comb begin
    acc = '0;
    for (int q = 0; q < 4; q++) begin
      base[q]  = acc[AW-1:0];
      depth[q] = (AW+1)'(blk_q[q]) * (AW+1)'(BLK_WORDS);
      acc      = acc + depth[q];
    end
  end

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr [4], rptr [4];
  logic [AW:0]   cnt  [4];

  logic       wp_v, wa_v, rp_v, ra_v, rsel_d, rsw, dv;
  logic [1:0] wp_q, wa_q, rp_q, ra_q;
  logic [AW:0] wcnt_now, wdep_now;

  wire w_hit   = waddr[IDW+1:2] == id_q;
  wire r_hit   = (raddr[IDW+2:3] == id_q) && !raddr[2];
  wire prs_hit = prst && wa_v && ra_v && (wa_q == ra_q);

  assign wcnt_now = cnt[wa_q];
  assign wdep_now = depth[wa_q];

  wire w_do = wen && wa_v && (wcnt_now != wdep_now) && !prs_hit;
  wire r_do = ra_v && (cnt[ra_q] != '0) && !prs_hit && (rsw || ren || !dv);

  assign wr_room     = wp_v && (cnt[wp_q] != depth[wp_q]);
  assign wr_afull_n  = !(wp_v && ((depth[wp_q] - cnt[wp_q]) <= af_q));
  assign rd_aempty_n = !(rp_v && (cnt[rp_q] <= ae_q));
  assign rd_void     = !dv;

  always_ff @(posedge clk)
    if (w_do) mem[base[wa_q] + wptr[wa_q]] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {wp_v, wa_v, rp_v, ra_v, rsel_d, rsw, dv} <= '0;
      {wp_q, wa_q, rp_q, ra_q} <= '0;
      rdata <= '0;
      for (int q = 0; q < 4; q++) begin
        wptr[q] <= '0;
        rptr[q] <= '0;
        cnt[q]  <= '0;
      end
    end else begin
      if (wsel) begin
        wp_v <= w_hit;
        wp_q <= waddr[1:0];
      end
      wa_v <= wp_v;
      wa_q <= wp_q;
      if (rsel) begin
        rp_v <= r_hit;
        rp_q <= raddr[1:0];
      end
      ra_v   <= rp_v;
      ra_q   <= rp_q;
      rsel_d <= rsel;
      rsw    <= rsel_d;

      if (r_do) begin
        rdata <= mem[base[ra_q] + rptr[ra_q]];
        dv    <= 1'b1;
      end else if (rsw || ren) begin
        dv    <= 1'b0;
      end

      for (int q = 0; q < 4; q++) begin
        if (prs_hit && wa_q == 2'(q)) begin
          wptr[q] <= '0;
          rptr[q] <= '0;
          cnt[q]  <= '0;
        end else begin
          if (w_do && wa_q == 2'(q))
            wptr[q] <= ({1'b0, wptr[q]} == depth[q] - 1'b1) ? '0 : wptr[q] + 1'b1;
          if (r_do && ra_q == 2'(q))
            rptr[q] <= ({1'b0, rptr[q]} == depth[q] - 1'b1) ? '0 : rptr[q] + 1'b1;
          cnt[q] <= cnt[q] + (AW+1)'(w_do && wa_q == 2'(q))
                           - (AW+1)'(r_do && ra_q == 2'(q));
        end
      end
    end
  end

endmodule

// File: rtl/mq_fifo_chk.sv
`timescale 1ns/1ps
module mq_fifo_chk #(
  parameter int DW  = 18,
  parameter int IDW = 3,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [IDW-1:0] id_q,
  input logic           wsel,
  input logic [IDW+1:0] waddr,
  input logic           wr_room,
  input logic           rsel,
  input logic [IDW+2:0] raddr,
  input logic           rd_void,
  input logic [DW-1:0]  rdata,
  input logic           wa_v,
  input logic [CW-1:0]  wcnt_now,
  input logic [CW-1:0]  wdep_now
);

  p_foreign_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wsel && (waddr[IDW+1:2] != id_q) |=> !wr_room);

  p_null_void_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsel && raddr[2] |-> ##3 rd_void);

  p_data_moves_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> !rd_void);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wa_v |-> wcnt_now <= wdep_now);

endmodule

bind mq_fifo mq_fifo_chk #(.DW(DW), .IDW(IDW), .CW(AW + 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .id_q     (id_q),
  .wsel     (wsel),
  .waddr    (waddr),
  .wr_room  (wr_room),
  .rsel     (rsel),
  .raddr    (raddr),
  .rd_void  (rd_void),
  .rdata    (rdata),
  .wa_v     (wa_v),
  .wcnt_now (wcnt_now),
  .wdep_now (wdep_now)
);

// File: tb/mq_fifo_test.sv
`timescale 1ns/1ps
module mq_fifo_test;
  localparam int DW = 18;
  localparam int AW = 7;
  localparam logic [2:0] ID = 3'd5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          b_wsel = 0, b_wen = 0, b_rsel = 0, b_ren = 0, b_prst = 0;
  logic [4:0]    b_waddr = '0;
  logic [5:0]    b_raddr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic          wr_room, wr_afull_n, rd_aempty_n, rd_void;
  logic [DW-1:0] rdata;

  mq_fifo uut (
    .clk(clk), .rst_n(rst_n), .dev_id(ID),
    .cfg_blocks({4'd3, 4'd0, 4'd2, 4'd1}),
    .cfg_ae_off(8'd2), .cfg_af_off(8'd3),
    .wsel(b_wsel), .waddr(b_waddr), .wen(b_wen), .wdata(b_wdata),
    .rsel(b_rsel), .raddr(b_raddr), .ren(b_ren), .prst(b_prst),
    .wr_room(wr_room), .wr_afull_n(wr_afull_n), .rd_aempty_n(rd_aempty_n),
    .rd_void(rd_void), .rdata(rdata)
  );

  int checks = 0, errors = 0;
  int dep [4] = '{16, 32, 0, 48};

  logic [DW-1:0] mq [4][$];
  logic [DW-1:0] od = '0;
  bit ov = 0, sw1 = 0, sw2 = 0;
  bit pw_v = 0, aw_v = 0, pr_v = 0, ar_v = 0;
  logic [1:0] pw_q = 0, aw_q = 0, pr_q = 0, ar_q = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit prs, wdo, take;
    int e_room, e_af, e_ae;
    prs  = b_prst && aw_v && ar_v && (aw_q == ar_q);
    wdo  = b_wen && aw_v && (mq[aw_q].size() < dep[aw_q]) && !prs;
    take = ar_v && (mq[ar_q].size() > 0) && !prs && (sw2 || b_ren || !ov);
    if (take) begin
      od = mq[ar_q].pop_front();
      ov = 1;
    end else if (sw2 || b_ren) ov = 0;
    if (wdo) mq[aw_q].push_back(b_wdata);
    if (prs) mq[aw_q].delete();
    sw2 = sw1; sw1 = b_rsel;
    ar_v = pr_v; ar_q = pr_q;
    if (b_rsel) begin pr_v = (b_raddr[5:3] == ID) && !b_raddr[2]; pr_q = b_raddr[1:0]; end
    aw_v = pw_v; aw_q = pw_q;
    if (b_wsel) begin pw_v = (b_waddr[4:2] == ID); pw_q = b_waddr[1:0]; end
    @(posedge clk); #2;
    b_wsel = 0; b_wen = 0; b_rsel = 0; b_ren = 0; b_prst = 0;
    e_room = (pw_v && mq[pw_q].size() < dep[pw_q]) ? 1 : 0;
    e_af   = (pw_v && (dep[pw_q] - mq[pw_q].size()) <= 3) ? 0 : 1;
    e_ae   = (pr_v && mq[pr_q].size() <= 2) ? 0 : 1;
    chk(wr_room == e_room, "R4 wr_room", wr_room, e_room);
    chk(wr_afull_n == e_af, "R10 wr_afull_n", wr_afull_n, e_af);
    chk(rd_aempty_n == e_ae, "R10 rd_aempty_n", rd_aempty_n, e_ae);
    chk(rd_void == !ov, "R6 rd_void", rd_void, !ov);
    chk(rdata == od, "R12 rdata", rdata, od);
  endtask

  task automatic sel_w(input logic [1:0] q, input logic [2:0] id);
    b_wsel = 1; b_waddr = {id, q}; step(); step();
  endtask

  task automatic sel_r(input logic [1:0] q, input logic [2:0] id, input logic nul);
    b_rsel = 1; b_raddr = {id, nul, q}; step(); step(); step();
  endtask

  task automatic wr(input int v);
    b_wen = 1; b_wdata = DW'(v); step();
  endtask

  task automatic rd();
    b_ren = 1; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R11 reset state
    chk(wr_room == 0, "R11 wr_room", wr_room, 0);
    chk(rd_void == 1, "R11 rd_void", rd_void, 1);
    chk(wr_afull_n == 1, "R11 wr_afull_n", wr_afull_n, 1);
    chk(rd_aempty_n == 1, "R11 rd_aempty_n", rd_aempty_n, 1);
    chk(rdata == 0, "R11 rdata", rdata, 0);

    sel_w(0, ID);
    chk(wr_room == 1, "R2 matched select", wr_room, 1);
    for (int i = 0; i < 12; i++) wr(100 + i);
    chk(wr_afull_n == 1, "R10 four free", wr_afull_n, 1);
    wr(112);
    chk(wr_afull_n == 0, "R10 three free", wr_afull_n, 0);
    for (int i = 13; i < 16; i++) wr(100 + i);
    chk(wr_room == 0, "R4 queue full", wr_room, 0);
    wr(199);

    // R3 write selection latency
    sel_w(3, ID);
    wr(600); wr(601);
    b_wsel = 1; b_waddr = {ID, 2'd1}; wr(602);
    wr(603); wr(604); wr(605);

    sel_w(1, 3'd2);
    chk(wr_room == 0, "R2 foreign id", wr_room, 0);
    wr(700);

    sel_w(2, ID);
    chk(wr_room == 0, "R1 zero-block queue full", wr_room, 0);
    chk(wr_afull_n == 0, "R1 zero-block almost full", wr_afull_n, 0);

    sel_r(3, ID, 0);
    chk(rd_void == 0, "R5 new queue head valid", rd_void, 0);
    chk(rdata == 600, "R5 new queue head", rdata, 600);
    rd(); chk(rdata == 601, "R3 q3 second", rdata, 601);
    rd(); chk(rdata == 602, "R3 write on select edge", rdata, 602);
    rd(); chk(rdata == 603, "R3 write edge after select", rdata, 603);
    rd();
    chk(rd_void == 1, "R6 read to empty", rd_void, 1);
    chk(rdata == 603, "R6 data held", rdata, 603);

    sel_w(3, ID);
    wr(610); wr(611); step();
    chk(rd_void == 0, "R6 fall through", rd_void, 0);
    chk(rdata == 610, "R6 fall through data", rdata, 610);

    b_rsel = 1; b_raddr = {ID, 1'b0, 2'd0}; step();
    rd();
    chk(rdata == 611, "R5 old queue after select", rdata, 611);
    step();
    chk(rdata == 100, "R5 forced load new queue", rdata, 100);

    sel_r(2, ID, 0);
    chk(rd_void == 1, "R7 empty new queue void", rd_void, 1);
    chk(rdata == 100, "R7 last word kept", rdata, 100);

    sel_r(1, ID, 0);
    chk(rdata == 604, "R5 q1 head", rdata, 604);
    sel_r(1, ID, 1);
    chk(rd_void == 1, "R8 null queue void", rd_void, 1);
    chk(rdata == 604, "R8 null keeps data", rdata, 604);
    chk(rd_aempty_n == 1, "R10 no queue", rd_aempty_n, 1);
    sel_r(1, 3'd1, 0);
    chk(rd_void == 1, "R8 foreign read id", rd_void, 1);

    sel_r(3, ID, 0);
    chk(rd_aempty_n == 0, "R10 empty queue", rd_aempty_n, 0);

    sel_w(1, ID);
    sel_r(0, ID, 0);
    chk(rdata == 101, "R5 q0 head", rdata, 101);
    b_prst = 1; step();
    chk(rd_aempty_n == 1, "R9 ignored when sides differ", rd_aempty_n, 1);
    rd();
    chk(rdata == 102, "R9 queue intact", rdata, 102);

    sel_w(0, ID);
    b_prst = 1; step();
    chk(rd_aempty_n == 0, "R9 queue emptied", rd_aempty_n, 0);
    chk(wr_room == 1, "R9 room after reset", wr_room, 1);
    chk(wr_afull_n == 1, "R9 not almost full", wr_afull_n, 1);
    chk(rdata == 102, "R9 output untouched", rdata, 102);
    rd();
    chk(rd_void == 1, "R9 nothing left", rd_void, 1);
    wr(900); step(); step();
    chk(rdata == 900, "R9 pointers restart", rdata, 900);
    sel_r(1, ID, 0);
    chk(rdata == 605, "R9 other queue untouched", rdata, 605);

    sel_w(1, ID);
    for (int i = 0; i < 36; i++) wr(1000 + i);
    chk(wr_room == 0, "R4 q1 full at 32", wr_room, 0);
    for (int i = 0; i < 34; i++) begin
      rd();
      if (i < 32) chk(rdata == 1000 + i, "R12 order", rdata, 1000 + i);
    end
    chk(rd_void == 1, "R12 drained", rd_void, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule